// File: doc/BRIEF.md
# Shared Bus Ownership Arbiter

This block sits between two processors and one shared memory and peripheral port. A supervising host processor and a subordinate signal processor both have a bus into the block. Exactly one of them is steered onto the shared port at a time. After reset the subordinate runs and owns the port. The host takes the port by writing a request code to a control word at a fixed host address.

A request sets the subordinate's hold line. Ownership moves to the host only once the subordinate answers with its hold acknowledge. The host can then load new code into shared memory. When it is done, it writes a release code. The block then keeps the subordinate in reset for a fixed number of clocks, so that it restarts from its first instruction. After that it drops both hold and reset and hands the port back.

A host access to the shared port while the host is not the owner is stalled. The block holds the host's ready low and does not forward the access. A subordinate access while the subordinate is not the owner is stalled in the same way. Reading the control word returns a status word. Bit 0 is set when the host owns the port. Bit 1 is set while a hold request waits for its acknowledge. All other bits read zero.

Top module: `shbus_arbiter`

## Requirements
- R1: After synchronous reset the subordinate owns the port. slave_hold and slave_rst are low, and the status word reads 0.
- R2: A host write of 0xA5A5 (low 16 bits) to address CTRL_ADDR while the subordinate owns the port raises slave_hold on the next cycle. The status then reads 0x0002 (bit 1 pending, bit 0 clear).
- R3: The host becomes owner (status 0x0001) only on the clock edge that samples slave_hlda high while a hold is pending. While the acknowledge stays low, the status stays 0x0002.
- R4: While the host is not the owner, a host access to any address other than CTRL_ADDR sees host_ready low and is not placed on the shared port. While the host is the owner, its request, write enable, address and write data appear on the shared port, and the port's read data and ready return to the host.
- R5: The subordinate bus is forwarded only while the subordinate owns the port or a hold is pending. At all other times subordinate accesses see slave_ready low.
- R6: A host write of 0x5A5A while the host owns the port asserts slave_rst for exactly RST_CYCLES clocks (8 by default), with slave_hold kept high. Both lines then drop, and the subordinate owns the port again (status 0).
- R7: A control write of any value other than 0xA5A5 or 0x5A5A leaves the ownership state and the status unchanged.
- R8: A request written while a hold is pending or the host owns the port has no effect. A release written while the subordinate owns the port or a hold is pending has no effect.
- R9: Host accesses to CTRL_ADDR complete in the same cycle (host_ready high) whatever the owner, and they are never forwarded to the shared port.
- R10: The shared port carries a request from at most one side at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access strobe |
| host_we | input | 1 | Host write enable |
| host_addr | input | AW | Host address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data (status word at CTRL_ADDR) |
| host_ready | output | 1 | Host access complete; low stalls |
| slave_req | input | 1 | Subordinate access strobe |
| slave_we | input | 1 | Subordinate write enable |
| slave_addr | input | AW | Subordinate address |
| slave_wdata | input | DW | Subordinate write data |
| slave_rdata | output | DW | Subordinate read data |
| slave_ready | output | 1 | Subordinate access complete; low stalls |
| slave_hold | output | 1 | Hold request to the subordinate |
| slave_hlda | input | 1 | Hold acknowledge from the subordinate |
| slave_rst | output | 1 | Reset to the subordinate |
| mem_req | output | 1 | Shared port strobe |
| mem_we | output | 1 | Shared port write enable |
| mem_addr | output | AW | Shared port address |
| mem_wdata | output | DW | Shared port write data |
| mem_rdata | input | DW | Shared port read data |
| mem_ready | input | 1 | Shared port ready |

## Verification
The assertions check on every cycle the properties that hold at every instant:
- exclusive use of the shared port;
- stalling of whichever side is not the owner;
- same-cycle completion of control accesses;
- no host ownership without a sampled acknowledge;
- reset of the subordinate only after host ownership, always under hold and always exactly RST_CYCLES long.

Only the bench's scenarios show the command decoding. That covers which codes are ignored in which state, the status values those writes leave behind, and the correct routing of addresses and data to and from the shared port.

// File: rtl/shbus_pkg.sv
package shbus_pkg;

    localparam int CODE_W = 16;
    localparam logic [CODE_W-1:0] CODE_TAKE = 16'hA5A5;
    localparam logic [CODE_W-1:0] CODE_GIVE = 16'h5A5A;

    typedef enum logic [1:0] {
        ST_SLAVE = 2'd0,
        ST_PEND  = 2'd1,
        ST_HOST  = 2'd2,
        ST_RSTP  = 2'd3
    } own_state_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_TAKE = 2'd1,
        CMD_GIVE = 2'd2
    } ctrl_cmd_e;

    typedef struct packed {
        logic pending;
        logic host_owns;
    } own_status_t;

    function automatic ctrl_cmd_e decode_code(input logic [CODE_W-1:0] w);
        if (w == CODE_TAKE)      return CMD_TAKE;
        else if (w == CODE_GIVE) return CMD_GIVE;
        else                     return CMD_NONE;
    endfunction

    function automatic logic host_side(input own_state_e s);
        return s == ST_HOST;
    endfunction

    function automatic logic slave_side(input own_state_e s);
        return (s == ST_SLAVE) || (s == ST_PEND);
    endfunction

endpackage

// File: rtl/shbus_ctrl_port.sv
module shbus_ctrl_port
    import shbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter logic [AW-1:0] CTRL_ADDR = '1
) (
    input  logic                host_req,
    input  logic                host_we,
    input  logic [AW-1:0]       host_addr,
    input  logic [DW-1:0]       host_wdata,
    input  own_state_e          state,
    output logic                ctrl_hit,
    output ctrl_cmd_e           cmd,
    output logic [DW-1:0]       stat_word
);
    own_status_t st;

    always_comb begin
        ctrl_hit = host_req && (host_addr == CTRL_ADDR);
        cmd      = CMD_NONE;
        if (ctrl_hit && host_we)
            cmd = decode_code(host_wdata[CODE_W-1:0]);
    end

    always_comb begin
        st.host_owns = host_side(state);
        st.pending   = (state == ST_PEND);
        stat_word    = '0;
        stat_word[$bits(own_status_t)-1:0] = st;
    end

endmodule

// File: rtl/shbus_own_fsm.sv
module shbus_own_fsm
    import shbus_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  ctrl_cmd_e  cmd,
    input  logic       slave_hlda,
    output own_state_e state,
    output logic       slave_hold,
    output logic       slave_rst
);
    localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

    logic [CNT_W-1:0] rcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_SLAVE;
            rcnt  <= '0;
        end else begin
            case (state)
                ST_SLAVE: if (cmd == CMD_TAKE) state <= ST_PEND;
                ST_PEND:  if (slave_hlda) state <= ST_HOST;
                ST_HOST:  if (cmd == CMD_GIVE) begin
                    state <= ST_RSTP;
                    rcnt  <= CNT_W'(RST_CYCLES - 1);
                end
                ST_RSTP: begin
                    if (rcnt == '0) state <= ST_SLAVE;
                    else            rcnt  <= rcnt - 1'b1;
                end
                default: state <= ST_SLAVE;
            endcase
        end
    end

    assign slave_hold = (state != ST_SLAVE);
    assign slave_rst  = (state == ST_RSTP);

endmodule

// File: rtl/shbus_steer.sv
module shbus_steer
    import shbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  own_state_e    state,
    input  logic          h_req,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    output logic          h_ready,
    input  logic          s_req,
    input  logic          s_we,
    input  logic [AW-1:0] s_addr,
    input  logic [DW-1:0] s_wdata,
    output logic [DW-1:0] s_rdata,
    output logic          s_ready,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [DW-1:0] m_wdata,
    input  logic [DW-1:0] m_rdata,
    input  logic          m_ready
);
    logic sel_host, sel_slave;

    assign sel_host  = host_side(state);
    assign sel_slave = slave_side(state);

    always_comb begin
        m_req   = 1'b0;
        m_we    = 1'b0;
        m_addr  = '0;
        m_wdata = '0;
        if (sel_host) begin
            m_req   = h_req;
            m_we    = h_we;
            m_addr  = h_addr;
            m_wdata = h_wdata;
        end else if (sel_slave) begin
            m_req   = s_req;
            m_we    = s_we;
            m_addr  = s_addr;
            m_wdata = s_wdata;
        end
    end

    always_comb begin
        h_rdata = sel_host  ? m_rdata : '0;
        h_ready = sel_host  ? m_ready : 1'b0;
        s_rdata = sel_slave ? m_rdata : '0;
        s_ready = sel_slave ? m_ready : 1'b0;
    end

endmodule

// File: rtl/shbus_arbiter.sv
module shbus_arbiter
    import shbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int RST_CYCLES = 8,
    parameter logic [AW-1:0] CTRL_ADDR = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_ready,
    input  logic          slave_req,
    input  logic          slave_we,
    input  logic [AW-1:0] slave_addr,
    input  logic [DW-1:0] slave_wdata,
    output logic [DW-1:0] slave_rdata,
    output logic          slave_ready,
    output logic          slave_hold,
    input  logic          slave_hlda,
    output logic          slave_rst,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready
);
    own_state_e    own_state;
    ctrl_cmd_e     cmd;
    logic          ctrl_hit;
    logic [DW-1:0] stat_word;
    logic [DW-1:0] bus_rdata;
    logic          bus_ready;

    shbus_ctrl_port #(.AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .state      (own_state),
        .ctrl_hit   (ctrl_hit),
        .cmd        (cmd),
        .stat_word  (stat_word)
    );

    shbus_own_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .slave_hlda (slave_hlda),
        .state      (own_state),
        .slave_hold (slave_hold),
        .slave_rst  (slave_rst)
    );

    shbus_steer #(.AW(AW), .DW(DW)) u_steer (
        .state   (own_state),
        .h_req   (host_req && !ctrl_hit),
        .h_we    (host_we),
        .h_addr  (host_addr),
        .h_wdata (host_wdata),
        .h_rdata (bus_rdata),
        .h_ready (bus_ready),
        .s_req   (slave_req),
        .s_we    (slave_we),
        .s_addr  (slave_addr),
        .s_wdata (slave_wdata),
        .s_rdata (slave_rdata),
        .s_ready (slave_ready),
        .m_req   (mem_req),
        .m_we    (mem_we),
        .m_addr  (mem_addr),
        .m_wdata (mem_wdata),
        .m_rdata (mem_rdata),
        .m_ready (mem_ready)
    );

    assign host_ready = ctrl_hit ? 1'b1 : bus_ready;
    assign host_rdata = ctrl_hit ? stat_word : bus_rdata;

endmodule

// File: rtl/shbus_arbiter_chk.sv
module shbus_arbiter_chk
    import shbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int RST_CYCLES = 8,
    parameter logic [AW-1:0] CTRL_ADDR = '1
) (
    input logic          clk,
    input logic          rst,
    input own_state_e    own_state,
    input logic          host_req,
    input logic [AW-1:0] host_addr,
    input logic          host_ready,
    input logic          slave_req,
    input logic          slave_ready,
    input logic          slave_hold,
    input logic          slave_hlda,
    input logic          slave_rst,
    input logic          mem_req
);
    int unsigned rst_len;

    always_ff @(posedge clk) begin
        if (rst)            rst_len <= 0;
        else if (slave_rst) rst_len <= rst_len + 1;
        else                rst_len <= 0;
    end

    // R3: host ownership needs a sampled acknowledge during the pending phase
    p_host_after_ack_r3: assert property (@(posedge clk) disable iff (rst)
        (own_state == ST_HOST && $past(own_state) != ST_HOST) |->
            ($past(slave_hlda) && $past(own_state) == ST_PEND));

    // R4: host stalled and not forwarded while not the owner
    p_host_stall_r4: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_addr != CTRL_ADDR && own_state != ST_HOST) |-> !host_ready);

    // R5: subordinate stalled while it is not the owner
    p_slave_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (slave_req && (own_state == ST_HOST || own_state == ST_RSTP)) |-> !slave_ready);

    // R6: reset pulse follows host ownership, is held under hold and has a fixed length
    p_rst_entry_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(slave_rst) |-> $past(own_state) == ST_HOST);
    p_rst_hold_r6: assert property (@(posedge clk) disable iff (rst)
        slave_rst |-> slave_hold);
    p_rst_len_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(slave_rst) |-> rst_len == RST_CYCLES);

    // R9: control accesses always complete at once
    p_ctrl_ready_r9: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_addr == CTRL_ADDR) |-> host_ready);

    // R10: only the owner may place a request on the shared port
    p_one_master_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ((own_state == ST_HOST && host_req && host_addr != CTRL_ADDR) ||
                     ((own_state == ST_SLAVE || own_state == ST_PEND) && slave_req)));

endmodule

bind shbus_arbiter shbus_arbiter_chk #(
    .AW(AW), .RST_CYCLES(RST_CYCLES), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .own_state   (own_state),
    .host_req    (host_req),
    .host_addr   (host_addr),
    .host_ready  (host_ready),
    .slave_req   (slave_req),
    .slave_ready (slave_ready),
    .slave_hold  (slave_hold),
    .slave_hlda  (slave_hlda),
    .slave_rst   (slave_rst),
    .mem_req     (mem_req)
);

// File: tb/shbus_arbiter_test.sv
module shbus_arbiter_test;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int RST_CYCLES = 8;
    localparam logic [AW-1:0] CTRL = 16'hFFFF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_req = 0, host_we = 0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic host_ready;
    logic slave_req = 0, slave_we = 0;
    logic [AW-1:0] slave_addr = '0;
    logic [DW-1:0] slave_wdata = '0;
    logic [DW-1:0] slave_rdata;
    logic slave_ready, slave_hold, slave_rst;
    logic slave_hlda = 0;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = 16'hBEEF;
    logic mem_ready = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    shbus_arbiter #(.AW(AW), .DW(DW), .RST_CYCLES(RST_CYCLES), .CTRL_ADDR(CTRL)) uut (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ready(host_ready),
        .slave_req(slave_req), .slave_we(slave_we), .slave_addr(slave_addr),
        .slave_wdata(slave_wdata), .slave_rdata(slave_rdata), .slave_ready(slave_ready),
        .slave_hold(slave_hold), .slave_hlda(slave_hlda), .slave_rst(slave_rst),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // {code written, acknowledge level afterwards, expected status}
    localparam logic [18:0] VECS [0:7] = '{
        {16'h1234, 1'b0, 2'b00},   // R7 unknown code ignored
        {16'h5A5A, 1'b0, 2'b00},   // R8 release while subordinate owns
        {16'hA5A5, 1'b0, 2'b10},   // R2 request -> pending
        {16'hA5A5, 1'b0, 2'b10},   // R8 request while pending; R3 no ack -> still pending
        {16'h5A5A, 1'b0, 2'b10},   // R8 release while pending
        {16'h0000, 1'b1, 2'b01},   // R3 ack -> host owns; R7 zero ignored
        {16'hA5A5, 1'b1, 2'b01},   // R8 request while host owns
        {16'hFFFF, 1'b1, 2'b01}    // R7 unknown code ignored
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ctrl_write(input logic [15:0] code);
        @(negedge clk);
        host_req = 1; host_we = 1; host_addr = CTRL; host_wdata = code;
        #1;
        chk("R9 ctrl write ready", {31'd0, host_ready}, 32'd1);
        chk("R9 ctrl write not forwarded", {31'd0, mem_req && mem_addr == CTRL}, 32'd0);
        @(negedge clk);
        host_req = 0; host_we = 0;
    endtask

    task automatic read_status(output logic [15:0] val);
        @(negedge clk);
        host_req = 1; host_we = 0; host_addr = CTRL;
        #1;
        val = host_rdata;
        @(negedge clk);
        host_req = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] st;
        int hi_cnt;
        logic hold_ok;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        chk("R1 hold after reset", {31'd0, slave_hold}, 32'd0);
        chk("R1 slave reset after reset", {31'd0, slave_rst}, 32'd0);
        read_status(st);
        chk("R1 status after reset", {16'd0, st}, 32'd0);

        // R5: subordinate forwarded when it owns
        @(negedge clk);
        slave_req = 1; slave_we = 1; slave_addr = 16'h0042; slave_wdata = 16'h1111;
        #1;
        chk("R5 slave addr forwarded", {16'd0, mem_addr}, 32'h0042);
        chk("R5 slave ready", {31'd0, slave_ready}, 32'd1);
        // R4: host stalled while subordinate owns
        host_req = 1; host_we = 0; host_addr = 16'h0010;
        #1;
        chk("R4 host stalled", {31'd0, host_ready}, 32'd0);
        chk("R4 host not forwarded", {16'd0, mem_addr}, 32'h0042);
        @(negedge clk);
        host_req = 0; slave_req = 0;

        for (int i = 0; i < 8; i++) begin
            ctrl_write(VECS[i][18:3]);
            @(negedge clk);
            slave_hlda = VECS[i][2];
            repeat (2) @(negedge clk);
            read_status(st);
            chk($sformatf("R2/R3/R7/R8 vector %0d status", i), {16'd0, st},
                {30'd0, VECS[i][1:0]});
            chk($sformatf("R2 vector %0d hold", i), {31'd0, slave_hold},
                {31'd0, VECS[i][1:0] != 2'b00});
            if (i == 2) begin
                // R5: still forwarded while hold pending
                @(negedge clk);
                slave_req = 1; slave_addr = 16'h0077;
                #1;
                chk("R5 slave forwarded while pending", {31'd0, slave_ready}, 32'd1);
                @(negedge clk);
                slave_req = 0;
            end
        end

        // R4/R5: host owns the port
        @(negedge clk);
        host_req = 1; host_we = 1; host_addr = 16'h0123; host_wdata = 16'hCAFE;
        slave_req = 1; slave_addr = 16'h0055;
        #1;
        chk("R4 host addr forwarded", {16'd0, mem_addr}, 32'h0123);
        chk("R4 host wdata forwarded", {16'd0, mem_wdata}, 32'hCAFE);
        chk("R4 host ready follows port", {31'd0, host_ready}, 32'd1);
        chk("R5 slave stalled while host owns", {31'd0, slave_ready}, 32'd0);
        host_we = 0;
        #1;
        chk("R4 host read data", {16'd0, host_rdata}, 32'hBEEF);
        mem_ready = 0;
        #1;
        chk("R4 host ready low when port busy", {31'd0, host_ready}, 32'd0);
        @(negedge clk);
        mem_ready = 1; host_req = 0; slave_req = 0;

        // R6: release and reset pulse
        ctrl_write(16'h5A5A);
        hi_cnt = 1;   // one high cycle already spent during the deassert negedge
        hold_ok = slave_rst && slave_hold;
        slave_hlda = 0;
        for (int c = 0; c < 14; c++) begin
            @(negedge clk);
            if (slave_rst) begin
                hi_cnt++;
                if (!slave_hold) hold_ok = 0;
                if (c == 2) begin
                    slave_req = 1;
                    #1;
                    chk("R5 slave stalled during reset", {31'd0, slave_ready}, 32'd0);
                    slave_req = 0;
                end
            end
        end
        chk("R6 reset pulse length", hi_cnt, RST_CYCLES);
        chk("R6 hold during reset", {31'd0, hold_ok}, 32'd1);
        chk("R6 hold released", {31'd0, slave_hold}, 32'd0);
        read_status(st);
        chk("R6 status after release", {16'd0, st}, 32'd0);

        // R1: reset while host owns
        ctrl_write(16'hA5A5);
        slave_hlda = 1;
        repeat (3) @(negedge clk);
        read_status(st);
        chk("R3 host owns again", {16'd0, st}, 32'h0001);
        rst = 1;
        @(negedge clk);
        rst = 0; slave_hlda = 0;
        #1;
        chk("R1 hold after mid-run reset", {31'd0, slave_hold}, 32'd0);
        read_status(st);
        chk("R1 status after mid-run reset", {16'd0, st}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule